// File: doc/BRIEF.md
# Receive Frame Status Capture Unit

This unit sits behind the receiver of an Ethernet-style data link controller. At the end of each frame the receiver pulses a completion strobe with six condition flags: overflow, CRC error, dribble error, short frame, end of frame and good frame. The unit first decides whether the frame is accepted. A two-bit match mode and the frame's address class (station, broadcast, multicast) make that decision. The match mode is latched when the frame starts.

For an accepted frame, the unit loads the flags into a host-readable status byte. A six-bit command mask marks which conditions make a frame "of interest". Loading a frame of interest clears a fresh/consumed bit, and that write-protects the byte until the host reads it. While the byte is protected, a later accepted frame does not overwrite it. Instead the unit emits a one-cycle discard pulse and a FIFO flush pulse. The same mask enables the interrupt. A host read clears the interrupt.

Top module: `rx_stat_capture`

## Requirements
- R1: After reset, `stat_byte` reads 0x80 (only bit 7 set), and `irq`, `rx_discard` and `fifo_flush` are 0.
- R2: A frame is accepted at `frame_done` according to the latched mode. Mode 0 accepts nothing and mode 1 accepts all frames. Mode 2 accepts frames with `is_station` or `is_bcast` set. Mode 3 also accepts frames with `is_mcast` set. A rejected frame changes no output.
- R3: The mode is captured from `match_mode` in the cycle `frame_start` is high. Later changes to `match_mode` have no effect until the next `frame_start`. Until the first `frame_start` after reset, the latched mode is 0.
- R4: Status flag layout in `stat_byte` and `rx_flags`: bit 0 overflow, bit 1 CRC error, bit 2 dribble, bit 3 short frame, bit 4 end of frame, bit 5 good frame, bit 7 fresh/consumed (1 = consumed).
- R5: An accepted frame arriving while bit 7 is 1 loads its flags into bits 5..0 one cycle after `frame_done`. Bit 7 stays 1 if no flag of the frame is set in `int_mask`.
- R6: An accepted frame with at least one flag set in `int_mask` clears bit 7 when it is loaded.
- R7: An accepted frame arriving while bit 7 is 0 (and no read in that cycle) leaves `stat_byte` unchanged. It pulses `rx_discard` and `fifo_flush` high for exactly one cycle, in the cycle after `frame_done`.
- R8: A `stat_rd` pulse sets bit 7 and clears `irq` on the next cycle.
- R9: `irq` is set on the cycle after `frame_done` of any accepted frame, including a discarded one, that has a flag enabled in `int_mask`. A set in the same cycle as a read wins.
- R10: When `stat_rd` and `frame_done` coincide, the read is applied first, and the frame is loaded as in R5/R6 without a discard.
- R11: Bit 6 of `stat_byte` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse at frame start; latches `match_mode` |
| match_mode | input | 2 | Acceptance mode 0..3 |
| is_station | input | 1 | Frame addressed to this station |
| is_bcast | input | 1 | Frame is broadcast |
| is_mcast | input | 1 | Frame is multicast |
| frame_done | input | 1 | Frame completion strobe |
| rx_flags | input | 6 | Condition flags of the completed frame |
| int_mask | input | 6 | Interrupt enable / frame-of-interest mask |
| stat_rd | input | 1 | Host read of the status byte |
| stat_byte | output | 8 | Status byte |
| irq | output | 1 | Receive interrupt |
| rx_discard | output | 1 | One-cycle discard pulse |
| fifo_flush | output | 1 | One-cycle receive FIFO clear |

## Verification
A host read and a frame completion can land in the same cycle. If the read is applied second, the unit wrongly discards a frame or wrongly keeps protection. The bench first captures a frame of interest so that the byte is protected. It then drives `stat_rd` and `frame_done` together and expects the new flags to load with no discard pulse. The interrupt set and the read clear can also collide, and a further case expects `irq` to stay high when a masked frame arrives together with a read.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int unsigned FLAG_W = 6;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned OLDNEW_BIT = 7;

  typedef enum logic [1:0] {
    MM_OFF      = 2'd0,
    MM_ALL      = 2'd1,
    MM_STN_BC   = 2'd2,
    MM_STN_BCMC = 2'd3
  } match_mode_e;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rx_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] match_mode,
  input  logic       is_station,
  input  logic       is_bcast,
  input  logic       is_mcast,
  input  logic       frame_done,
  output logic       accept
);
  match_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (frame_start) mode_d = match_mode_e'(match_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MM_OFF;
    else        mode_q <= mode_d;
  end

  logic addr_hit;
  always_comb begin
    unique case (mode_q)
      MM_OFF:      addr_hit = 1'b0;
      MM_ALL:      addr_hit = 1'b1;
      MM_STN_BC:   addr_hit = is_station | is_bcast;
      MM_STN_BCMC: addr_hit = is_station | is_bcast | is_mcast;
      default:     addr_hit = 1'b0;
    endcase
  end

  assign accept = frame_done & addr_hit;
endmodule

// File: rtl/rx_stat_reg.sv
module rx_stat_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] mask,
  input  logic         rd,
  output logic [W-1:0] stat_flags,
  output logic         consumed,
  output logic         discard,
  output logic         flush
);
  logic [W-1:0] flags_q, flags_d;
  logic         cons_q, cons_d;
  logic         disc_q, disc_d;
  logic         cons_eff, of_interest, load_en;

  // read is applied before the frame is evaluated
  assign cons_eff    = cons_q | rd;
  assign of_interest = |(flags & mask);
  assign load_en     = accept & cons_eff;

  always_comb begin
    flags_d = flags_q;
    cons_d  = cons_eff;
    disc_d  = accept & ~cons_eff;
    if (load_en) begin
      flags_d = flags;
      cons_d  = ~of_interest;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cons_q  <= 1'b1;
      disc_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      cons_q  <= cons_d;
      disc_q  <= disc_d;
    end
  end

  assign stat_flags = flags_q;
  assign consumed   = cons_q;
  assign discard    = disc_q;
  assign flush      = disc_q;
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] mask,
  input  logic         rd,
  output logic         irq
);
  logic irq_q, irq_d, set_en;

  assign set_en = accept & (|(flags & mask));

  always_comb begin
    irq_d = irq_q;
    if (rd)     irq_d = 1'b0;
    if (set_en) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/rx_stat_capture.sv
module rx_stat_capture
  import rx_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        match_mode,
  input  logic              is_station,
  input  logic              is_bcast,
  input  logic              is_mcast,
  input  logic              frame_done,
  input  logic [FLAG_W-1:0] rx_flags,
  input  logic [FLAG_W-1:0] int_mask,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_byte,
  output logic              irq,
  output logic              rx_discard,
  output logic              fifo_flush
);
  logic              rst_n_s;
  logic              accept;
  logic [FLAG_W-1:0] stat_flags;
  logic              consumed;

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  rx_accept_filter u_filt (
    .clk(clk), .rst_n(rst_n_s), .frame_start(frame_start),
    .match_mode(match_mode), .is_station(is_station), .is_bcast(is_bcast),
    .is_mcast(is_mcast), .frame_done(frame_done), .accept(accept)
  );

  rx_stat_reg #(.W(FLAG_W)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .flags(rx_flags),
    .mask(int_mask), .rd(stat_rd), .stat_flags(stat_flags),
    .consumed(consumed), .discard(rx_discard), .flush(fifo_flush)
  );

  rx_irq_gen #(.W(FLAG_W)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .flags(rx_flags),
    .mask(int_mask), .rd(stat_rd), .irq(irq)
  );

  always_comb begin
    stat_byte = '0;
    stat_byte[FLAG_W-1:0] = stat_flags;
    stat_byte[OLDNEW_BIT] = consumed;
  end
endmodule

// File: rtl/rx_stat_capture_chk.sv
module rx_stat_capture_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic       accept,
  input logic       frame_done,
  input logic       stat_rd,
  input logic [7:0] stat_byte,
  input logic       irq,
  input logic       rx_discard,
  input logic       fifo_flush
);
  p_bit6_zero_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    stat_byte[6] == 1'b0);

  p_discard_protected_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept && !stat_byte[7] && !stat_rd |=> rx_discard && fifo_flush);

  p_hold_protected_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !stat_byte[7] && !stat_rd |=> $stable(stat_byte));

  p_no_discard_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    stat_rd |=> !rx_discard);

  p_rejected_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_done && !accept |=> !rx_discard);

  p_read_sets_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    stat_rd && !frame_done |=> stat_byte[7] && !irq);

  p_flush_with_discard_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_discard == fifo_flush);
endmodule

bind rx_stat_capture rx_stat_capture_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .accept(accept), .frame_done(frame_done),
  .stat_rd(stat_rd), .stat_byte(stat_byte), .irq(irq),
  .rx_discard(rx_discard), .fifo_flush(fifo_flush)
);

// File: tb/rx_stat_capture_tb.sv
module rx_stat_capture_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start, is_station, is_bcast, is_mcast, frame_done, stat_rd;
  logic [1:0] match_mode;
  logic [5:0] rx_flags, int_mask;
  logic [7:0] stat_byte;
  logic       irq, rx_discard, fifo_flush;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    logic       disc;
    string      tag;
  } exp_t;
  exp_t q[$];

  // model state
  logic [1:0] m_mode;
  logic [7:0] m_stat;
  logic       m_irq;

  always #2 clk = ~clk;

  rx_stat_capture u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .match_mode(match_mode),
    .is_station(is_station), .is_bcast(is_bcast), .is_mcast(is_mcast),
    .frame_done(frame_done), .rx_flags(rx_flags), .int_mask(int_mask),
    .stat_rd(stat_rd), .stat_byte(stat_byte), .irq(irq),
    .rx_discard(rx_discard), .fifo_flush(fifo_flush)
  );

  task automatic check(input string tag, input logic [7:0] a, input logic [7:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // monitor: pops one expected item after each driven edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check({it.tag, " stat"}, stat_byte, it.st);
        check({it.tag, " irq"}, {7'd0, irq}, {7'd0, it.irq});
        check({it.tag, " discard"}, {6'd0, fifo_flush, rx_discard}, {6'd0, it.disc, it.disc});
      end
    end
  end

  // driver: one cycle of stimulus, model update, push expectation
  task automatic step(input logic fs, input logic [1:0] mm, input logic fd,
                      input logic [2:0] addr, input logic [5:0] fl,
                      input logic rd, input string tag);
    logic acc, hit, foi, cons;
    exp_t it;
    @(negedge clk);
    frame_start = fs; match_mode = mm; frame_done = fd;
    {is_station, is_bcast, is_mcast} = addr;
    rx_flags = fl; stat_rd = rd;
    case (m_mode)
      2'd0: hit = 1'b0;
      2'd1: hit = 1'b1;
      2'd2: hit = addr[2] | addr[1];
      default: hit = |addr;
    endcase
    acc  = fd & hit;
    foi  = |(fl & int_mask);
    cons = m_stat[7] | rd;
    it.disc = acc & ~cons;
    if (acc && cons) m_stat = {~foi, 1'b0, fl};
    else             m_stat[7] = cons;
    if (rd) m_irq = 1'b0;
    if (acc && foi) m_irq = 1'b1;
    if (fs) m_mode = mm;
    it.st = m_stat; it.irq = m_irq; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b0, match_mode, 1'b0, 3'b000, 6'd0, 1'b0, tag);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_start = 0; match_mode = 0; frame_done = 0;
    is_station = 0; is_bcast = 0; is_mcast = 0;
    rx_flags = 0; stat_rd = 0; int_mask = 6'b100001;
    m_mode = 0; m_stat = 8'h80; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset stat", stat_byte, 8'h80);
    check("R1 reset outs", {5'd0, irq, rx_discard, fifo_flush}, 8'h00);

    // R3: frame before any frame_start uses mode 0 -> rejected (R2)
    step(0, 2'd1, 1, 3'b000, 6'b010000, 0, "R3 unlatched mode rejects");
    // R2 mode 1 accepts all; R5 non-interest frame keeps bit7 (R4 layout)
    step(1, 2'd1, 0, 3'b000, 6'd0, 0, "R2 latch mode1");
    step(0, 2'd1, 1, 3'b000, 6'b010100, 0, "R5 non-interest load R4");
    // R2 mode 2 rejects multicast only
    step(1, 2'd2, 0, 3'b000, 6'd0, 0, "R2 latch mode2");
    step(0, 2'd2, 1, 3'b001, 6'b100000, 0, "R2 mode2 rejects mcast");
    step(0, 2'd2, 1, 3'b010, 6'b011000, 0, "R2 mode2 accepts bcast");
    // R3: latch mode 3 then change to 0 mid-frame
    step(1, 2'd3, 0, 3'b000, 6'd0, 0, "R3 latch mode3");
    step(0, 2'd0, 1, 3'b001, 6'b000010, 0, "R3 mid-frame change ignored");
    // R6 frame of interest clears bit7, R9 irq
    step(0, 2'd0, 1, 3'b001, 6'b110000, 0, "R6 interest load R9");
    idle("R6 hold");
    // R7 protected: discard, no load, irq from discarded frame
    step(0, 2'd0, 1, 3'b100, 6'b000001, 0, "R7 protected discard");
    idle("R7 one-cycle pulse");
    step(0, 2'd0, 1, 3'b100, 6'b000100, 0, "R7 protected non-interest");
    // R8 read sets bit7, clears irq
    step(0, 2'd0, 0, 3'b000, 6'd0, 1, "R8 read");
    idle("R8 after read");
    // re-protect then R10 coincident read+done
    step(0, 2'd0, 1, 3'b100, 6'b100001, 0, "R6 reprotect");
    step(0, 2'd0, 1, 3'b100, 6'b001000, 1, "R10 read with done");
    idle("R10 after");
    // R9 set wins over read clear
    step(0, 2'd0, 1, 3'b100, 6'b000001, 1, "R9 set wins read");
    step(0, 2'd0, 0, 3'b000, 6'd0, 1, "R9 read clears");
    // mode 0 latched: everything rejected
    step(1, 2'd0, 0, 3'b000, 6'd0, 0, "R2 latch mode0");
    step(0, 2'd0, 1, 3'b111, 6'b111111, 0, "R2 mode0 rejects R11");
    idle("R2 mode0 quiet");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard left %0d items", q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule